// File: doc/BRIEF.md
# Software Interrupt Entry and Return Sequencer

This block carries out the memory side of a software interrupt. It takes a command, an 8-bit interrupt type and the current flag word, code segment, instruction pointer, stack pointer and stack segment. It then runs the stack and vector-table transfers over a single 16-bit memory port and returns the updated flag word, CS, IP and SP.

On entry, the block saves the flag word and the return address on the stack. It then fetches the handler address from a table of 4-byte entries at the bottom of memory, and clears the interrupt-enable and trap flags. The overflow-conditional variant takes effect only when the overflow flag is set, and always uses type 4. Interrupt return pops the three words back.

The memory port uses a request/ready handshake. A transfer completes on each clock edge where both the request and the ready signal are high. A one-cycle done pulse marks the end of each command.

Top module: `trap_seq`

## Requirements
- R1: After synchronous reset, busy, done and mem_req are 0.
- R2: An entry command pushes three words as writes (mem_we=1): first the flag word, then CS, then IP. Each write goes to SS×16 + (SP−2), where SP is the value left by the previous push, so SP ends 6 below its starting value.
- R3: After the pushes, entry reads the word at physical address type×4 into IP, then the word at type×4+2 into CS.
- R4: When entry completes, ip_out and cs_out hold the two vector words and sp_out equals sp_in−6.
- R5: The pushed flag word equals flags_in. After entry, flags_out equals flags_in with bit 9 (interrupt enable) and bit 8 (trap) cleared and every other bit unchanged.
- R6: The overflow command (cmd_op=2'b10) with bit 11 of flags_in set behaves as entry with type 4, reading addresses 10h and 12h. The cmd_type input is ignored.
- R7: The overflow command with bit 11 clear makes no memory request. It raises done on the cycle after acceptance, and the outputs equal the inputs.
- R8: Return (cmd_op=2'b11) reads IP from SS×16+SP, CS from SS×16+SP+2 and flags from SS×16+SP+4. After return, sp_out = sp_in+6 and flags_out is the popped word unchanged.
- R9: While mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold their values.
- R10: The command codes are 01 (typed interrupt), 10 (overflow) and 11 (return). A command with code 00, or any command while busy is high, is ignored. done is a single-cycle pulse on the cycle after the last accepted transfer, and busy is low whenever done is high.
- R11: SP arithmetic wraps modulo 2^16, and physical stack addresses wrap modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | Command code |
| cmd_type | input | 8 | Interrupt type number |
| flags_in | input | 16 | Current flag word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| ss_in | input | 16 | Current stack segment |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Transfer accepted this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| flags_out | output | 16 | Resulting flag word |
| cs_out | output | 16 | Resulting code segment |
| ip_out | output | 16 | Resulting instruction pointer |
| sp_out | output | 16 | Resulting stack pointer |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 4-bit segment shift, 8-bit types and type 4 for the overflow case. With these values, a stack segment of FFFFh combined with a small SP reaches both the 16-bit SP wrap and the 20-bit physical wrap. It also lets type FFh exercise the last vector entry at 3FCh. Random ready stalls on every transfer exercise the hold rule. An entry followed by a return restores the saved state exactly.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SWI  = 2'b01,
    OP_OVF  = 2'b10,
    OP_RET  = 2'b11
  } trap_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_F,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_VEC_IP,
    ST_VEC_CS,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_F
  } trap_state_e;
endpackage

// File: rtl/trap_step_ctrl.sv
module trap_step_ctrl
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  trap_op_e    op,
  input  logic        ovf_flag,
  input  logic        xfer,
  output trap_state_e state,
  output logic        accept,
  output logic        done,
  output logic        busy
);
  trap_state_e nxt;
  logic        fin;

  always_comb begin
    busy   = (state != ST_IDLE);
    accept = cmd_valid && (state == ST_IDLE) && (op != OP_NONE);
  end

  always_comb begin
    nxt = state;
    fin = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          case (op)
            OP_SWI: nxt = ST_PUSH_F;
            OP_OVF: begin
              if (ovf_flag) nxt = ST_PUSH_F;
              else          fin = 1'b1;
            end
            OP_RET: nxt = ST_POP_IP;
            default: nxt = ST_IDLE;
          endcase
        end
      end
      ST_PUSH_F:  if (xfer) nxt = ST_PUSH_CS;
      ST_PUSH_CS: if (xfer) nxt = ST_PUSH_IP;
      ST_PUSH_IP: if (xfer) nxt = ST_VEC_IP;
      ST_VEC_IP:  if (xfer) nxt = ST_VEC_CS;
      ST_VEC_CS:  if (xfer) begin nxt = ST_IDLE; fin = 1'b1; end
      ST_POP_IP:  if (xfer) nxt = ST_POP_CS;
      ST_POP_CS:  if (xfer) nxt = ST_POP_F;
      ST_POP_F:   if (xfer) begin nxt = ST_IDLE; fin = 1'b1; end
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= fin;
    end
  end
endmodule

// File: rtl/trap_ctx_regs.sv
module trap_ctx_regs
  import trap_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int TYPE_W   = 8,
  parameter int OVF_TYPE = 4,
  parameter int IE_POS   = 9,
  parameter int TR_POS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  trap_op_e          op,
  input  logic [TYPE_W-1:0] type_in,
  input  logic [WORD_W-1:0] flags_in,
  input  logic [WORD_W-1:0] cs_in,
  input  logic [WORD_W-1:0] ip_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [WORD_W-1:0] ss_in,
  input  trap_state_e       state,
  input  logic              xfer,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] flags_q,
  output logic [WORD_W-1:0] cs_q,
  output logic [WORD_W-1:0] ip_q,
  output logic [WORD_W-1:0] sp_q,
  output logic [WORD_W-1:0] ss_q,
  output logic [TYPE_W-1:0] vtype_q
);
  localparam logic [WORD_W-1:0] STEP     = WORD_W'(2);
  localparam logic [WORD_W-1:0] KEEP_MSK =
    ~((WORD_W'(1) << IE_POS) | (WORD_W'(1) << TR_POS));

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      sp_q    <= '0;
      ss_q    <= '0;
      vtype_q <= '0;
    end else if (accept) begin
      flags_q <= flags_in;
      cs_q    <= cs_in;
      ip_q    <= ip_in;
      sp_q    <= sp_in;
      ss_q    <= ss_in;
      vtype_q <= (op == OP_OVF) ? TYPE_W'(OVF_TYPE) : type_in;
    end else if (xfer) begin
      case (state)
        ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP: sp_q <= sp_q - STEP;
        ST_VEC_IP: ip_q <= rdata;
        ST_VEC_CS: begin
          cs_q    <= rdata;
          flags_q <= flags_q & KEEP_MSK;
        end
        ST_POP_IP: begin ip_q <= rdata;    sp_q <= sp_q + STEP; end
        ST_POP_CS: begin cs_q <= rdata;    sp_q <= sp_q + STEP; end
        ST_POP_F:  begin flags_q <= rdata; sp_q <= sp_q + STEP; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trap_port_map.sv
module trap_port_map
  import trap_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int TYPE_W    = 8,
  localparam int ADDR_W   = WORD_W + SEG_SHIFT
) (
  input  trap_state_e       state,
  input  logic [WORD_W-1:0] flags_q,
  input  logic [WORD_W-1:0] cs_q,
  input  logic [WORD_W-1:0] ip_q,
  input  logic [WORD_W-1:0] sp_q,
  input  logic [WORD_W-1:0] ss_q,
  input  logic [TYPE_W-1:0] vtype_q,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata
);
  localparam int VEC_W = TYPE_W + 2;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

  logic [ADDR_W-1:0] vec_base;
  logic [ADDR_W-1:0] stk_top;
  logic [ADDR_W-1:0] stk_push;

  function automatic logic [ADDR_W-1:0] phys(input logic [WORD_W-1:0] seg,
                                             input logic [WORD_W-1:0] off);
    return {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
  endfunction

  always_comb begin
    vec_base = {{(ADDR_W-VEC_W){1'b0}}, vtype_q, 2'b00};
    stk_top  = phys(ss_q, sp_q);
    stk_push = phys(ss_q, sp_q - STEP);
    req      = (state != ST_IDLE);
    we       = 1'b0;
    addr     = '0;
    wdata    = '0;
    case (state)
      ST_PUSH_F:  begin we = 1'b1; addr = stk_push; wdata = flags_q; end
      ST_PUSH_CS: begin we = 1'b1; addr = stk_push; wdata = cs_q;    end
      ST_PUSH_IP: begin we = 1'b1; addr = stk_push; wdata = ip_q;    end
      ST_VEC_IP:  addr = vec_base;
      ST_VEC_CS:  addr = vec_base | ADDR_W'(2);
      ST_POP_IP, ST_POP_CS, ST_POP_F: addr = stk_top;
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int TYPE_W    = 8,
  parameter int OVF_TYPE  = 4,
  parameter int OF_POS    = 11,
  parameter int IE_POS    = 9,
  parameter int TR_POS    = 8,
  localparam int ADDR_W   = WORD_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic [WORD_W-1:0] flags_in,
  input  logic [WORD_W-1:0] cs_in,
  input  logic [WORD_W-1:0] ip_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [WORD_W-1:0] ss_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] flags_out,
  output logic [WORD_W-1:0] cs_out,
  output logic [WORD_W-1:0] ip_out,
  output logic [WORD_W-1:0] sp_out
);
  trap_state_e       state;
  trap_op_e          op;
  logic              accept;
  logic              xfer;
  logic [WORD_W-1:0] ss_q;
  logic [TYPE_W-1:0] vtype_q;

  assign op   = trap_op_e'(cmd_op);
  assign xfer = mem_req && mem_ready;

  trap_step_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .op       (op),
    .ovf_flag (flags_in[OF_POS]),
    .xfer     (xfer),
    .state    (state),
    .accept   (accept),
    .done     (done),
    .busy     (busy)
  );

  trap_ctx_regs #(
    .WORD_W(WORD_W), .TYPE_W(TYPE_W), .OVF_TYPE(OVF_TYPE),
    .IE_POS(IE_POS), .TR_POS(TR_POS)
  ) u_ctx (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .op      (op),
    .type_in (cmd_type),
    .flags_in(flags_in),
    .cs_in   (cs_in),
    .ip_in   (ip_in),
    .sp_in   (sp_in),
    .ss_in   (ss_in),
    .state   (state),
    .xfer    (xfer),
    .rdata   (mem_rdata),
    .flags_q (flags_out),
    .cs_q    (cs_out),
    .ip_q    (ip_out),
    .sp_q    (sp_out),
    .ss_q    (ss_q),
    .vtype_q (vtype_q)
  );

  trap_port_map #(
    .WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT), .TYPE_W(TYPE_W)
  ) u_port (
    .state  (state),
    .flags_q(flags_out),
    .cs_q   (cs_out),
    .ip_q   (ip_out),
    .sp_q   (sp_out),
    .ss_q   (ss_q),
    .vtype_q(vtype_q),
    .req    (mem_req),
    .we     (mem_we),
    .addr   (mem_addr),
    .wdata  (mem_wdata)
  );
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
  import trap_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 20,
  parameter int OF_POS = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [WORD_W-1:0] flags_in,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] sp_out
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ready && mem_we |=> (sp_out + WORD_W'(2)) == $past(sp_out));

  // R7
  untaken_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && cmd_valid && cmd_op == OP_OVF && !flags_in[OF_POS]
      |=> done && !busy && !mem_req);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
endmodule

bind trap_seq trap_seq_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OF_POS(OF_POS)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .flags_in (flags_in),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ready(mem_ready),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .busy     (busy),
  .done     (done),
  .sp_out   (sp_out)
);

// File: tb/trap_seq_tb_top.sv
`timescale 1ns/1ps
module trap_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [7:0]  cmd_type = 8'h00;
  logic [15:0] flags_in = 16'h0, cs_in = 16'h0, ip_in = 16'h0, sp_in = 16'h0, ss_in = 16'h0;
  logic        mem_req, mem_we, busy, done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0;
  logic        mem_ready = 1'b0;
  logic [15:0] flags_out, cs_out, ip_out, sp_out;

  int checks = 0;
  int errors = 0;
  int mem [int];
  int q_we[$];
  int q_addr[$];
  int q_data[$];

  always #2 clk = ~clk;

  trap_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_type(cmd_type),
    .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in), .ss_in(ss_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
    .flags_out(flags_out), .cs_out(cs_out), .ip_out(ip_out), .sp_out(sp_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rd(input int a);
    if (mem.exists(a)) return mem[a];
    return 0;
  endfunction

  function automatic int phys(input int seg, input int off);
    return ((seg << 4) + (off & 16'hFFFF)) & 20'hFFFFF;
  endfunction

  task automatic expect_xfer(input int we, input int a, input int d);
    q_we.push_back(we);
    q_addr.push_back(a);
    q_data.push_back(d);
  endtask

  task automatic check_outs(input string req, input int ef, input int ec,
                            input int ei, input int es);
    chk(int'(flags_out) == ef, req, "flags_out", int'(flags_out), ef);
    chk(int'(cs_out) == ec, req, "cs_out", int'(cs_out), ec);
    chk(int'(ip_out) == ei, req, "ip_out", int'(ip_out), ei);
    chk(int'(sp_out) == es, req, "sp_out", int'(sp_out), es);
  endtask

  // Behavioural reference: builds the expected transfer list and results,
  // then compares the ports every cycle.
  task automatic run_cmd(input logic [1:0] op, input logic [7:0] ty,
                         input int fl, input int c, input int i,
                         input int s, input int sg, input bit noise,
                         input string req);
    int ef, ec, ei, es, vt, spw, cyc;
    bit taken, fin;
    int vals[3];
    q_we.delete(); q_addr.delete(); q_data.delete();
    taken = (op == 2'b01) || (op == 2'b11) || (op == 2'b10 && fl[11]);
    vt = (op == 2'b10) ? 4 : int'(ty);
    ef = fl; ec = c; ei = i; es = s;
    if (taken && op != 2'b11) begin
      vals[0] = fl; vals[1] = c; vals[2] = i;
      spw = s;
      for (int k = 0; k < 3; k++) begin
        spw = (spw - 2) & 16'hFFFF;
        expect_xfer(1, phys(sg, spw), vals[k]);
      end
      expect_xfer(0, vt * 4, 0);
      expect_xfer(0, vt * 4 + 2, 0);
      ei = rd(vt * 4); ec = rd(vt * 4 + 2);
      ef = fl & 16'hFCFF; es = (s - 6) & 16'hFFFF;
    end else if (op == 2'b11) begin
      for (int k = 0; k < 3; k++) expect_xfer(0, phys(sg, s + 2 * k), 0);
      ei = rd(phys(sg, s)); ec = rd(phys(sg, s + 2)); ef = rd(phys(sg, s + 4));
      es = (s + 6) & 16'hFFFF;
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_type = ty;
    flags_in = 16'(fl); cs_in = 16'(c); ip_in = 16'(i); sp_in = 16'(s); ss_in = 16'(sg);
    @(negedge clk);
    if (noise && taken) begin
      cmd_op = 2'b01; cmd_type = 8'h5A; flags_in = 16'hFFFF;
      cs_in = 16'h0BAD; ip_in = 16'h0BAD; sp_in = 16'h7777; ss_in = 16'h3333;
    end else cmd_valid = 1'b0;
    fin = !taken;
    cyc = 0;
    while (!fin) begin
      chk(busy && !done, req, "busy during sequence", int'({busy, done}), 2);
      chk(mem_req == 1'b1, req, "mem_req", int'(mem_req), 1);
      chk(int'(mem_we) == q_we[0], req, "mem_we", int'(mem_we), q_we[0]);
      chk(int'(mem_addr) == q_addr[0], req, "mem_addr", int'(mem_addr), q_addr[0]);
      if (q_we[0] == 1)
        chk(int'(mem_wdata) == q_data[0], req, "mem_wdata", int'(mem_wdata), q_data[0]);
      mem_rdata = 16'(rd(int'(mem_addr)));
      mem_ready = ($urandom_range(0, 2) != 0);
      if (mem_ready) begin
        if (mem_we) mem[int'(mem_addr)] = int'(mem_wdata);
        void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
        if (q_we.size() == 0) fin = 1'b1;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      mem_ready = 1'b0;
      cyc++;
      if (cyc > 200) begin
        chk(1'b0, req, "sequence length", cyc, 5);
        fin = 1'b1;
      end
    end
    // R10 done pulse one cycle after the last transfer
    chk(done && !busy && !mem_req, req, "done/busy/req at completion",
        int'({done, busy, mem_req}), 4);
    check_outs(req, ef, ec, ei, es);
    @(negedge clk);
    chk(!done && !busy, "R10", "done single pulse", int'({done, busy}), 0);
    check_outs(req, ef, ec, ei, es);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem[32'h84]  = 16'hABCD; mem[32'h86]  = 16'h4000;
    mem[32'h10]  = 16'h1111; mem[32'h12]  = 16'h2222;
    mem[32'h1DC] = 16'hDEAD; mem[32'h1DE] = 16'hBEEF;
    mem[32'h3FC] = 16'h3C3C; mem[32'h3FE] = 16'h5A5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req, "R1", "busy/done/req in reset",
        int'({busy, done, mem_req}), 0);
    rst = 1'b0;
    // R2 R3 R4 R5 typed entry, with noise on the inputs while busy (R10)
    run_cmd(2'b01, 8'h21, 16'h0F00, 16'h1234, 16'h5678, 16'h0100, 16'h2000, 1'b1, "R2_R3_R4_R5");
    // R8 return restores the saved context
    run_cmd(2'b11, 8'h00, 16'h0C00, 16'h4000, 16'hABCD, 16'h00FA, 16'h2000, 1'b0, "R8");
    // R6 taken overflow: type input ignored, fixed vectors at 10h/12h
    run_cmd(2'b10, 8'h77, 16'h0B42, 16'h0100, 16'h0200, 16'h0800, 16'h0050, 1'b0, "R6");
    // R7 untaken overflow
    run_cmd(2'b10, 8'h21, 16'h0300, 16'h0A0A, 16'h0B0B, 16'h0C0C, 16'h0D0D, 1'b0, "R7");
    // R11 stack wrap with last vector entry
    run_cmd(2'b01, 8'hFF, 16'h0000, 16'h9999, 16'h8888, 16'h0002, 16'hFFFF, 1'b0, "R11");
    run_cmd(2'b11, 8'h00, 16'h0000, 16'h5A5A, 16'h3C3C, 16'hFFFC, 16'hFFFF, 1'b0, "R11_R8");
    // R10 code 00 ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; flags_in = 16'h1234; sp_in = 16'h4444;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy && !done && !mem_req, "R10", "code 00 ignored",
        int'({busy, done, mem_req}), 0);
    check_outs("R10", 16'h0000, 16'h9999, 16'h8888, 16'h0002);
    // R9 is also exercised by the random ready stalls above
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule